// File: doc/BRIEF.md
# Dual-Channel Datapath Self-Test Engine

This block exercises the digital sample path of a two-channel converter without any analog stimulus. A one-cycle start strobe launches a run: for a fixed number of cycles an internal pseudorandom generator replaces the converter samples of every selected channel at the entry of the datapath. The datapath keeps driving its outputs throughout, so the pseudorandom words can be watched on the sample outputs while the run is in progress. The run stops by itself.

The formatted datapath output of one channel is compacted into a 16-bit multiple-input signature register, and the result is published as a low byte and a high byte when the run ends. Channel A is compacted whenever it is selected, so with both channels selected the result is channel A's. Because channel B's formatting stage differs from channel A's, the signature tells which configuration was run. A control input chooses whether the generator starts each run from its seed or carries on from where the previous run stopped.

Top module: `dp_bist_engine`

## Requirements
- R1: While and after reset, busy and done are low, both signature bytes are zero and the generator state is all ones.
- R2: A start strobe seen while idle raises busy on the next cycle; busy stays high for exactly 513 cycles. Done clears on the cycle after an accepted start, rises on the cycle busy falls, and holds until the next accepted start.
- R3: The generator is a 9-bit shift register stepping as next = {s[7:0], s[8] ^ s[4]} (x^9 + x^5 + 1); its sample is the state zero-extended to 11 bits. It supplies 512 consecutive samples per run, and sample k appears on the output of each selected channel k+2 cycles after the clock edge that accepted the start.
- R4: Channel select bit 0 chooses channel A and bit 1 chooses channel B, captured when the start is accepted; an unselected channel keeps carrying its converter input during the run.
- R5: Each channel output is its input registered for one cycle; channel A passes the word unchanged and channel B inverts bit 10.
- R6: The signature register is cleared when a run starts and, for each of the 512 test words d leaving the compacted channel, becomes {m[14:0],0} XOR (m[15] ? 0x1021 : 0) XOR d (x^16 + x^12 + x^5 + 1).
- R7: Channel A's output is compacted whenever select bit 0 is set, also when both bits are set; otherwise channel B's. The low byte output carries signature bits 7:0 and the high byte bits 15:8.
- R8: The signature outputs hold their value during a run and change only on the cycle busy falls, to the final signature.
- R9: With the restart input high at start the generator is reloaded with all ones; with it low the run continues from the state left by the previous run.
- R10: Start strobes that arrive while busy have no effect on the run length, the stimulus or the signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle run request |
| chan_sel_i | input | 2 | Bit 0 channel A, bit 1 channel B |
| pn_restart_i | input | 1 | 1: reload generator seed at start, 0: continue |
| adc_a_i | input | 11 | Converter samples, channel A |
| adc_b_i | input | 11 | Converter samples, channel B |
| dout_a_o | output | 11 | Datapath output, channel A |
| dout_b_o | output | 11 | Datapath output, channel B |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Last run completed |
| sig_lo_o | output | 8 | Signature bits 7:0 |
| sig_hi_o | output | 8 | Signature bits 15:8 |

## Verification
The hardest case to reach from the ports is a run in continue mode, because its expected stimulus depends on the generator state left behind by every earlier run. The bench keeps its own generator state across all runs and chains restart and continue runs back to back, so a continued run starts from a state one step past the seed. A stray start pulse in the middle of one run and a channel-B-only run show that the run length is fixed and that the configuration reaches the signature.

// File: rtl/dpb_pkg.sv
package dpb_pkg;

  localparam int NUM_CH   = 2;
  localparam int SAMPLE_W = 11;
  localparam int SIG_W    = 16;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_t;

  typedef logic [SAMPLE_W-1:0] sample_t;

endpackage

// File: rtl/dpb_ctrl.sv
module dpb_ctrl
  import dpb_pkg::*;
#(
  parameter int RUN_LEN = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic accept_o,
  output logic inject_o,
  output logic compact_o,
  output logic finish_o,
  output logic busy_o,
  output logic done_o
);

  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN);

  run_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             cnt_en;

  always_comb begin
    accept_o  = (state_q == ST_IDLE) && start_i;
    inject_o  = (state_q == ST_RUN) && (cnt_q < LAST);
    compact_o = (state_q == ST_RUN) && (cnt_q != '0);
    finish_o  = (state_q == ST_RUN) && (cnt_q == LAST);
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = done_q;
    cnt_en  = 1'b0;
    if (accept_o) begin
      state_d = ST_RUN;
      cnt_d   = '0;
      done_d  = 1'b0;
      cnt_en  = 1'b1;
    end else if (finish_o) begin
      state_d = ST_IDLE;
      done_d  = 1'b1;
    end else if (state_q == ST_RUN) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy_o = (state_q == ST_RUN);
  assign done_o = done_q;

  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && !done_o)); // R2
  AST_RUN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && cnt_q == LAST) |=> (!busy_o && done_o)); // R2
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o); // R2
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && cnt_q != LAST) |=> (busy_o && cnt_q != '0)); // R10

endmodule

// File: rtl/dpb_pn_source.sv
module dpb_pn_source
  import dpb_pkg::*;
#(
  parameter int LFSR_W = 9,
  parameter int FB_TAP = 4,
  parameter int OUT_W  = SAMPLE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_seed_i,
  input  logic             step_i,
  output logic [OUT_W-1:0] sample_o
);

  localparam logic [LFSR_W-1:0] SEED = '1;

  logic [LFSR_W-1:0] st_q, st_d;
  logic              st_en;
  logic              fb;

  always_comb begin
    fb    = st_q[LFSR_W-1] ^ st_q[FB_TAP];
    st_d  = st_q;
    st_en = 1'b0;
    if (load_seed_i) begin
      st_d  = SEED;
      st_en = 1'b1;
    end else if (step_i) begin
      st_d  = {st_q[LFSR_W-2:0], fb};
      st_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SEED;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  assign sample_o = OUT_W'(st_q);

  AST_PN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != '0); // R3
  AST_PN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_seed_i && !step_i) |=> $stable(st_q)); // R9

endmodule

// File: rtl/dpb_chan_path.sv
module dpb_chan_path
  import dpb_pkg::*;
#(
  parameter int W       = SAMPLE_W,
  parameter bit INV_MSB = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inject_i,
  input  logic [W-1:0] pn_i,
  input  logic [W-1:0] adc_i,
  output logic [W-1:0] dout_o
);

  localparam logic [W-1:0] FMT_MASK = INV_MSB ? {1'b1, {(W-1){1'b0}}} : '0;

  logic [W-1:0] src;
  logic [W-1:0] dout_q, dout_d;
  logic         dout_en;

  always_comb begin
    src     = inject_i ? pn_i : adc_i;
    dout_d  = src ^ FMT_MASK;
    dout_en = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
    end else if (dout_en) begin
      dout_q <= dout_d;
    end
  end

  assign dout_o = dout_q;

  AST_LIVE_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !inject_i |=> ((dout_o ^ FMT_MASK) == $past(adc_i))); // R4
  AST_LIVE_PN: assert property (@(posedge clk) disable iff (!rst_n)
    inject_i |=> ((dout_o ^ FMT_MASK) == $past(pn_i))); // R3

endmodule

// File: rtl/dpb_misr.sv
module dpb_misr
  import dpb_pkg::*;
#(
  parameter int             W    = SIG_W,
  parameter int             IN_W = SAMPLE_W,
  parameter logic [W-1:0]   POLY = 16'h1021
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear_i,
  input  logic            en_i,
  input  logic [IN_W-1:0] data_i,
  output logic [W-1:0]    sig_next_o
);

  logic [W-1:0] m_q, m_d, shifted;
  logic         m_en;

  always_comb begin
    shifted    = {m_q[W-2:0], 1'b0} ^ (m_q[W-1] ? POLY : '0);
    sig_next_o = shifted ^ W'(data_i);
    m_d        = m_q;
    m_en       = 1'b0;
    if (clear_i) begin
      m_d  = '0;
      m_en = 1'b1;
    end else if (en_i) begin
      m_d  = sig_next_o;
      m_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= '0;
    end else if (m_en) begin
      m_q <= m_d;
    end
  end

  AST_MISR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (m_q == '0)); // R6

endmodule

// File: rtl/dp_bist_engine.sv
module dp_bist_engine
  import dpb_pkg::*;
#(
  parameter int RUN_LEN = 512,
  parameter int LFSR_W  = 9,
  parameter int FB_TAP  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [NUM_CH-1:0]     chan_sel_i,
  input  logic                  pn_restart_i,
  input  logic [SAMPLE_W-1:0]   adc_a_i,
  input  logic [SAMPLE_W-1:0]   adc_b_i,
  output logic [SAMPLE_W-1:0]   dout_a_o,
  output logic [SAMPLE_W-1:0]   dout_b_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [SIG_W/2-1:0]    sig_lo_o,
  output logic [SIG_W/2-1:0]    sig_hi_o
);

  localparam int HALF = SIG_W / 2;

  logic                accept, inject, compact, finish;
  sample_t             pn_sample;
  sample_t             adc_arr  [NUM_CH];
  sample_t             dout_arr [NUM_CH];
  logic [NUM_CH-1:0]   sel_q, sel_d;
  logic                sel_en;
  sample_t             cmp_word;
  logic [SIG_W-1:0]    misr_next;
  logic [SIG_W-1:0]    sig_q, sig_d;
  logic                sig_en;

  dpb_ctrl #(.RUN_LEN(RUN_LEN)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .accept_o  (accept),
    .inject_o  (inject),
    .compact_o (compact),
    .finish_o  (finish),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  dpb_pn_source #(.LFSR_W(LFSR_W), .FB_TAP(FB_TAP), .OUT_W(SAMPLE_W)) u_pn (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_seed_i (accept && pn_restart_i),
    .step_i      (inject),
    .sample_o    (pn_sample)
  );

  // Run configuration is frozen at the accepted start.
  always_comb begin
    sel_d  = chan_sel_i;
    sel_en = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_en) begin
      sel_q <= sel_d;
    end
  end

  assign adc_arr[0] = adc_a_i;
  assign adc_arr[1] = adc_b_i;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dpb_chan_path #(.W(SAMPLE_W), .INV_MSB(g == 1)) u_path (
      .clk      (clk),
      .rst_n    (rst_n),
      .inject_i (inject && sel_q[g]),
      .pn_i     (pn_sample),
      .adc_i    (adc_arr[g]),
      .dout_o   (dout_arr[g])
    );
  end

  assign dout_a_o = dout_arr[0];
  assign dout_b_o = dout_arr[1];

  // Channel A takes the single signature slot whenever it is selected.
  always_comb begin
    cmp_word = sel_q[0] ? dout_arr[0] : dout_arr[1];
  end

  dpb_misr #(.W(SIG_W), .IN_W(SAMPLE_W), .POLY(16'h1021)) u_misr (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (accept),
    .en_i       (compact),
    .data_i     (cmp_word),
    .sig_next_o (misr_next)
  );

  always_comb begin
    sig_d  = misr_next;
    sig_en = finish;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q <= '0;
    end else if (sig_en) begin
      sig_q <= sig_d;
    end
  end

  assign sig_lo_o = sig_q[HALF-1:0];
  assign sig_hi_o = sig_q[SIG_W-1:HALF];

  AST_SIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |=> $stable(sig_q)); // R8
  AST_SIG_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && finish) |=> (!busy_o && done_o)); // R8
  AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !finish) |=> $stable(sel_q)); // R4

endmodule

// File: tb/sim_dp_bist_engine.sv
`timescale 1ns/1ps
module sim_dp_bist_engine;

  typedef struct packed {
    logic [10:0] a;
    logic [10:0] b;
  } pair_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [1:0]  chan_sel_i;
  logic        pn_restart_i;
  logic [10:0] adc_a_i, adc_b_i;
  logic [10:0] dout_a_o, dout_b_o;
  logic        busy_o, done_o;
  logic [7:0]  sig_lo_o, sig_hi_o;

  int    n_chk  = 0;
  int    n_fail = 0;
  int    bj     = 0;
  logic  pb     = 1'b0;
  logic [8:0] mdl_st;
  pair_t      dq[$];
  logic [15:0] sq[$];

  always #2.5 clk = ~clk;

  dp_bist_engine u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_sel_i(chan_sel_i),
    .pn_restart_i(pn_restart_i), .adc_a_i(adc_a_i), .adc_b_i(adc_b_i),
    .dout_a_o(dout_a_o), .dout_b_o(dout_b_o), .busy_o(busy_o), .done_o(done_o),
    .sig_lo_o(sig_lo_o), .sig_hi_o(sig_hi_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sig_now();
    return {sig_hi_o, sig_lo_o};
  endfunction

  // Driver: builds the expected stream and signature, then launches the run.
  task automatic run(input logic [1:0] sel, input bit restart, input bit poke,
                     output logic [15:0] exp_sig);
    logic [8:0]  st;
    logic [15:0] m;
    logic [15:0] prev;
    pair_t       e;
    st = restart ? 9'h1FF : mdl_st;
    m  = '0;
    for (int i = 0; i < 512; i++) begin
      e.a = sel[0] ? {2'b00, st} : adc_a_i;
      e.b = (sel[1] ? {2'b00, st} : adc_b_i) ^ 11'h400;
      dq.push_back(e);
      m  = {m[14:0], 1'b0} ^ (m[15] ? 16'h1021 : 16'h0000) ^
           {5'b0, (sel[0] ? e.a : e.b)};
      st = {st[7:0], st[8] ^ st[4]};
    end
    mdl_st  = st;
    exp_sig = m;
    sq.push_back(m);
    prev = sig_now();
    @(negedge clk);
    start_i = 1'b1; chan_sel_i = sel; pn_restart_i = restart;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R2 busy after start", 32'(busy_o), 1);
    chk(done_o == 1'b0, "R2 done cleared", 32'(done_o), 0);
    chk(sig_now() == prev, "R8 signature held", 32'(sig_now()), 32'(prev));
    if (poke) begin
      repeat (100) @(negedge clk);
      start_i = 1'b1; chan_sel_i = 2'b10; pn_restart_i = ~restart;
      @(negedge clk);
      start_i = 1'b0;
      chk(sig_now() == prev, "R10 mid-run start", 32'(sig_now()), 32'(prev));
    end
    while (busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(done_o == 1'b1, "R2 done holds", 32'(done_o), 1);
    chk(busy_o == 1'b0, "R10 no extra run", 32'(busy_o), 0);
    chk(sig_now() == m, "R8 signature kept", 32'(sig_now()), 32'(m));
  endtask

  // Monitor: compares outputs against the queues while runs are in flight.
  initial begin
    pair_t       e;
    logic [15:0] s;
    forever begin
      @(negedge clk);
      if (rst_n && busy_o) begin
        if (bj >= 1 && dq.size() > 0) begin
          e = dq.pop_front();
          chk(dout_a_o == e.a, "R3 channel A output", 32'(dout_a_o), 32'(e.a));
          chk(dout_b_o == e.b, "R5 channel B output", 32'(dout_b_o), 32'(e.b));
        end
        bj++;
      end else if (pb) begin
        chk(bj == 513, "R2 busy length", 32'(bj), 513);
        chk(dq.size() == 0, "R3 sample count", 32'(dq.size()), 0);
        if (sq.size() > 0) begin
          s = sq.pop_front();
          chk(sig_now() == s, "R6 signature", 32'(sig_now()), 32'(s));
        end
        bj = 0;
      end
      pb = busy_o;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] sa, sb, sab, sc, sr;
    rst_n = 1'b0; start_i = 1'b0; chan_sel_i = 2'b01; pn_restart_i = 1'b1;
    adc_a_i = 11'h123; adc_b_i = 11'h0F0;
    mdl_st = 9'h1FF;
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0, "R1 busy in reset", 32'(busy_o), 0);
    chk(done_o == 1'b0, "R1 done in reset", 32'(done_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sig_now() == 16'h0, "R1 signature after reset", 32'(sig_now()), 0);
    chk(dout_b_o == (adc_b_i ^ 11'h400), "R4 live input idle", 32'(dout_b_o),
        32'(adc_b_i ^ 11'h400));
    // Continue mode straight from reset starts at the all-ones seed (R1, R9).
    run(2'b01, 1'b0, 1'b0, sr);
    run(2'b01, 1'b1, 1'b1, sa);
    chk(sa == sr, "R1 seed equals reset state", 32'(sa), 32'(sr));
    adc_a_i = 11'h7FF; adc_b_i = 11'h055;
    run(2'b10, 1'b1, 1'b0, sb);
    chk(sb != sa, "R7 configuration changes signature", 32'(sb), 32'(sa));
    run(2'b11, 1'b1, 1'b0, sab);
    chk(sab == sa, "R7 both selected gives channel A", 32'(sab), 32'(sa));
    run(2'b01, 1'b0, 1'b0, sc);
    chk(sc != sa, "R9 continue differs from restart", 32'(sc), 32'(sa));
    run(2'b01, 1'b1, 1'b0, sr);
    chk(sr == sa, "R9 restart reproduces seed run", 32'(sr), 32'(sa));
    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule